// File: doc/BRIEF.md
# Floppy Controller Host Bus Front End

This block is the processor-facing side of a floppy disk controller. A host reaches it over an 8-bit strobed bus: chip select, separate read and write strobes, and one address bit that picks the status byte or the data port. The data bus is split into an input, an output and an output enable, so the pad ring owns the tri-state buffer. A DMA channel may also reach the data port on its own, using the acknowledge pin in place of chip select. It raises a request pin while result bytes wait, and it can stop a transfer early with terminal count.

Two commands are decoded. The first loads the drive timing values (step rate, head unload, head load) plus a DMA-mode bit. The second is the interrupt status query, which the host uses to acknowledge the ready interrupt raised after reset. Every other opcode is answered with a one-byte invalid status. Reset returns the sequencer to idle and holds the drive-side pins low, but leaves the timing values as they were. If the drive reports ready while reset is held, an interrupt follows a fixed number of clocks after release.

The bus is a strobe bus, not a valid/ready stream. The status byte plays the part of back-pressure: the host must see the ready bit (bit 7) set before it moves a data byte. The direction bit (bit 6) tells the host which way that byte goes.

Top module: `fdc_host_if`

## Requirements
- R1: While both cs_n and dack_n are high, the read strobe, write strobe, a0 and db_in have no effect, and db_oe stays 0.
- R2: With cs_n low, a0=0 reads the status byte and a0=1 reaches the data port. With dack_n low, the data port is reached whatever the values of cs_n and a0.
- R3: The status byte is bit 7 ready, bit 6 direction (1 = controller to host), bit 4 busy, and all other bits 0. It reads 0x80 when idle. Ready reads 0 for RQM_HOLD clocks (default 2) after each byte written to the data port.
- R4: Opcode 0x03 is followed by two bytes. Byte one gives step_rate = bits 7:4 and unload_time = bits 3:0. Byte two gives load_time = bits 7:1 and selects DMA mode when bit 0 is 0.
- R5: Reset returns the block to idle (status 0x80), drives drv_out to all zeros and clears int_req. It leaves step_rate, unload_time and load_time unchanged.
- R6: If rdy is high on the last clock of reset, int_req rises INT_DELAY clocks after release (default 8192). If rdy is low then, int_req stays low.
- R7: Opcode 0x08 with the interrupt pending yields result bytes 0xC0 then 0x00, with status 0xD0 meanwhile. int_req falls once the last byte has been read.
- R8: Opcode 0x08 with no interrupt pending, and any opcode other than 0x03 or 0x08, yields the single result byte 0x80.
- R9: A data-port write during the result phase discards the pending results and leaves the single byte 0x80. A pending interrupt stays raised.
- R10: drq is 1 only in the result phase, in DMA mode, while ready is set. Reset returns the block to non-DMA mode.
- R11: If tc is high when a DMA data read ends, the result phase ends (status 0x80). This counts as having read the interrupt status.
- R12: A result byte is consumed when its read strobe ends. Status reads have no side effect. A data read outside the result phase returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register select: 0 status, 1 data |
| db_in | input | 8 | Bus data from host |
| db_out | output | 8 | Bus data to host |
| db_oe | output | 1 | Enable for the external bus driver |
| dack_n | input | 1 | DMA acknowledge, active low |
| drq | output | 1 | DMA request |
| tc | input | 1 | Terminal count |
| int_req | output | 1 | Interrupt request |
| rdy | input | 1 | Drive ready |
| drv_out | output | DRV_W | Drive-side control pins, held low |
| step_rate | output | 4 | Stored step rate code |
| unload_time | output | 4 | Stored head unload code |
| load_time | output | 7 | Stored head load code |

## Verification
The bench sweeps every opcode byte. A decoder that matches only part of the byte would start a specify or query sequence for some stray opcode, and its status would read 0x90 instead of 0xD0. It times the ready interrupt against the clock count after release. An off-by-one counter, or one that samples rdy at the wrong moment, shows up on one side of that window. It also stresses reset with timing values loaded, a write during the result phase, and a DMA read ended by terminal count. A block that cleared the timing values, appended the invalid byte after the old results, or ignored tc would return the wrong byte or keep int_req high.

// File: rtl/fdc_host_pkg.sv
`timescale 1ns/1ps
package fdc_host_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SPEC1, ST_SPEC2, ST_RESULT} seq_st_e;

  localparam logic [7:0] OP_SPECIFY    = 8'h03;
  localparam logic [7:0] OP_SENSE_INT  = 8'h08;
  localparam logic [7:0] RES_INVALID   = 8'h80;
  localparam logic [7:0] RES_READY_CHG = 8'hC0;
  localparam logic [7:0] RES_CYLINDER  = 8'h00;
endpackage

// File: rtl/fdc_bus_port.sv
`timescale 1ns/1ps
// Host strobe decode: selects the register, finds strobe edges, drives the bus.
module fdc_bus_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic       dack_n,
  input  logic       tc,
  input  logic [7:0] db_in,
  input  logic [7:0] stat,
  input  logic [7:0] data_rd,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       rd_done,
  output logic       rd_tc
);
  logic access, data_sel, rd_on, rd_data_on, wr_data_on;
  logic wr_q, rdd_q, tc_q;

  assign access     = ~cs_n | ~dack_n;
  assign data_sel   = ~dack_n | a0;
  assign rd_on      = access & ~rd_n;
  assign rd_data_on = rd_on & data_sel;
  assign wr_data_on = access & ~wr_n & data_sel;

  always_ff @(posedge clk) begin
    wr_q  <= wr_data_on;
    rdd_q <= rd_data_on;
    tc_q  <= rd_data_on & ~dack_n & tc;
  end

  // writes act on the leading strobe edge, reads retire on the trailing edge
  assign wr_stb  = ~rst & wr_data_on & ~wr_q;
  assign wr_byte = db_in;
  assign rd_done = ~rst & rdd_q & ~rd_data_on;
  assign rd_tc   = rd_done & tc_q;

  assign db_oe  = rd_on;
  assign db_out = data_sel ? data_rd : stat;
endmodule

// File: rtl/fdc_cmd_seq.sv
`timescale 1ns/1ps
// Command/result sequencer with specify storage and status byte.
module fdc_cmd_seq
  import fdc_host_pkg::*;
#(
  parameter int RQM_HOLD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_done,
  input  logic       rd_tc,
  input  logic       irq_pend,
  output logic [7:0] stat,
  output logic [7:0] data_rd,
  output logic [3:0] step_rate,
  output logic [3:0] unload_time,
  output logic [6:0] load_time,
  output logic       drq,
  output logic       irq_clr
);
  localparam int HOLD_W = (RQM_HOLD > 0) ? $clog2(RQM_HOLD + 1) : 1;

  seq_st_e           st;
  logic [7:0]        res_q [2];
  logic              idx_q, last_q, sense_q, non_dma_q;
  logic [HOLD_W-1:0] hold_q;
  logic              rqm, in_result, final_rd;

  assign in_result = (st == ST_RESULT);
  assign rqm       = (hold_q == '0);
  assign final_rd  = rd_done & in_result & ((idx_q == last_q) | rd_tc);

  // timing values survive reset on purpose: no reset branch
  always_ff @(posedge clk) begin
    if (wr_stb && st == ST_SPEC1) {step_rate, unload_time} <= wr_byte;
    if (wr_stb && st == ST_SPEC2) load_time <= wr_byte[7:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx_q     <= 1'b0;
      last_q    <= 1'b0;
      sense_q   <= 1'b0;
      non_dma_q <= 1'b1;
      hold_q    <= '0;
      res_q[0]  <= '0;
      res_q[1]  <= '0;
    end else begin
      if (!rqm) hold_q <= hold_q - 1'b1;
      if (wr_stb) begin
        hold_q <= HOLD_W'(RQM_HOLD);
        idx_q  <= 1'b0;
        unique case (st)
          ST_IDLE: begin
            if (wr_byte == OP_SPECIFY) begin
              st <= ST_SPEC1;
            end else if (wr_byte == OP_SENSE_INT && irq_pend) begin
              res_q[0] <= RES_READY_CHG;
              res_q[1] <= RES_CYLINDER;
              last_q   <= 1'b1;
              sense_q  <= 1'b1;
              st       <= ST_RESULT;
            end else begin
              res_q[0] <= RES_INVALID;
              last_q   <= 1'b0;
              sense_q  <= 1'b0;
              st       <= ST_RESULT;
            end
          end
          ST_SPEC1: st <= ST_SPEC2;
          ST_SPEC2: begin
            non_dma_q <= wr_byte[0];
            st        <= ST_IDLE;
          end
          ST_RESULT: begin
            res_q[0] <= RES_INVALID;
            last_q   <= 1'b0;
            sense_q  <= 1'b0;
          end
        endcase
      end else if (rd_done && in_result) begin
        if (final_rd) begin
          st      <= ST_IDLE;
          idx_q   <= 1'b0;
          sense_q <= 1'b0;
        end else begin
          idx_q <= 1'b1;
        end
      end
    end
  end

  assign irq_clr = final_rd & sense_q & ~wr_stb;
  assign data_rd = in_result ? res_q[idx_q] : 8'h00;
  assign stat    = {rqm, in_result, 1'b0, (st != ST_IDLE), 4'b0000};
  assign drq     = in_result & ~non_dma_q & rqm;
endmodule

// File: rtl/fdc_ready_irq.sv
`timescale 1ns/1ps
// Post-reset drive-ready interrupt: arms in reset, fires after a fixed count.
module fdc_ready_irq #(
  parameter int INT_DELAY = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy,
  input  logic irq_clr,
  output logic irq
);
  localparam int CNT_W = $clog2(INT_DELAY + 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= rdy;
      cnt_q   <= '0;
      irq     <= 1'b0;
    end else begin
      if (armed_q) begin
        if (cnt_q == CNT_W'(INT_DELAY - 1)) begin
          irq     <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_host_if.sv
`timescale 1ns/1ps
module fdc_host_if #(
  parameter int INT_DELAY = 8192,
  parameter int RQM_HOLD  = 2,
  parameter int DRV_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             a0,
  input  logic [7:0]       db_in,
  output logic [7:0]       db_out,
  output logic             db_oe,
  input  logic             dack_n,
  output logic             drq,
  input  logic             tc,
  output logic             int_req,
  input  logic             rdy,
  output logic [DRV_W-1:0] drv_out,
  output logic [3:0]       step_rate,
  output logic [3:0]       unload_time,
  output logic [6:0]       load_time
);
  logic [7:0] stat_w, data_w, wr_byte_w;
  logic       wr_stb_w, rd_done_w, rd_tc_w, irq_clr_w;

  fdc_bus_port u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .dack_n(dack_n), .tc(tc), .db_in(db_in), .stat(stat_w), .data_rd(data_w),
    .db_out(db_out), .db_oe(db_oe), .wr_stb(wr_stb_w), .wr_byte(wr_byte_w),
    .rd_done(rd_done_w), .rd_tc(rd_tc_w)
  );

  fdc_cmd_seq #(.RQM_HOLD(RQM_HOLD)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb_w), .wr_byte(wr_byte_w),
    .rd_done(rd_done_w), .rd_tc(rd_tc_w), .irq_pend(int_req),
    .stat(stat_w), .data_rd(data_w), .step_rate(step_rate),
    .unload_time(unload_time), .load_time(load_time), .drq(drq),
    .irq_clr(irq_clr_w)
  );

  fdc_ready_irq #(.INT_DELAY(INT_DELAY)) u_irq (
    .clk(clk), .rst(rst), .rdy(rdy), .irq_clr(irq_clr_w), .irq(int_req)
  );

  // drive-side pins are not operated by this front end; held at their idle level
  assign drv_out = '0;
endmodule

// File: rtl/fdc_host_if_chk.sv
`timescale 1ns/1ps
module fdc_host_if_chk #(
  parameter int RQM_HOLD = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       dack_n,
  input logic       db_oe,
  input logic       drq,
  input logic       int_req,
  input logic [7:0] stat,
  input logic       wr_stb,
  input logic       rd_done,
  input logic [3:0] step_rate,
  input logic [3:0] unload_time,
  input logic [6:0] load_time
);
  assert_bus_float_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && dack_n) |-> !db_oe);

  assert_dir_busy_R3: assert property (@(posedge clk) disable iff (rst)
    stat[6] |-> stat[4]);

  generate
    if (RQM_HOLD > 0) begin : g_hold
      assert_rqm_hold_R3: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !stat[7]);
    end
  endgenerate

  assert_timing_keep_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable({step_rate, unload_time, load_time}));

  assert_irq_reset_R6: assert property (@(posedge clk)
    rst |=> !int_req);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(int_req) |-> $past(rd_done));

  assert_drq_result_R10: assert property (@(posedge clk) disable iff (rst)
    drq |-> (stat[6] && stat[7]));
endmodule

bind fdc_host_if fdc_host_if_chk #(.RQM_HOLD(RQM_HOLD)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dack_n(dack_n), .db_oe(db_oe),
  .drq(drq), .int_req(int_req), .stat(stat_w), .wr_stb(wr_stb_w),
  .rd_done(rd_done_w), .step_rate(step_rate), .unload_time(unload_time),
  .load_time(load_time)
);

// File: tb/fdc_host_if_tb.sv
`timescale 1ns/1ps
module fdc_host_if_tb_top;
  localparam int INT_DELAY = 40;
  localparam int RQM_HOLD  = 2;
  localparam int DRV_W     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, dack_n = 1'b1, tc = 1'b0, rdy = 1'b1;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out;
  logic db_oe, drq, int_req;
  logic [DRV_W-1:0] drv_out;
  logic [3:0] step_rate, unload_time;
  logic [6:0] load_time;

  int errs = 0;
  int nchk = 0;

  always #2.5 clk = ~clk;

  fdc_host_if #(.INT_DELAY(INT_DELAY), .RQM_HOLD(RQM_HOLD), .DRV_W(DRV_W)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .dack_n(dack_n), .drq(drq),
    .tc(tc), .int_req(int_req), .rdy(rdy), .drv_out(drv_out),
    .step_rate(step_rate), .unload_time(unload_time), .load_time(load_time)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_data(input logic [7:0] b, input logic via_dma, output logic [7:0] peek);
    @(negedge clk); db_in = b; a0 = 1'b1;
    if (via_dma) dack_n = 1'b0; else cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1; dack_n = 1'b1; cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0;
    #1 peek = db_out;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (RQM_HOLD + 1) @(negedge clk);
  endtask

  task automatic rd_reg(input logic sel, input logic via_dma, input logic tcv, output logic [7:0] v);
    @(negedge clk); a0 = sel; tc = tcv;
    if (via_dma) dack_n = 1'b0; else cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); #1 v = db_out;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; dack_n = 1'b1; tc = 1'b0;
  endtask

  task automatic do_reset(input logic rdy_v);
    @(negedge clk); rst = 1'b1; rdy = rdy_v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v, pk;
    logic [7:0] b1, b2;

    // reset state, ready interrupt timing
    repeat (3) @(negedge clk);
    chk("R5 drv_out low in reset", 8'(drv_out), 8'h00);
    chk("R6 int low in reset", 8'(int_req), 8'h00);
    rst = 1'b0;
    repeat (INT_DELAY - 2) @(negedge clk);
    chk("R6 int not yet", 8'(int_req), 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 int raised", 8'(int_req), 8'h01);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R3 idle status", v, 8'h80);
    chk("R5 drv_out low", 8'(drv_out), 8'h00);
    chk("R10 drq idle", 8'(drq), 8'h00);

    // data read outside result phase
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R12 idle data read", v, 8'h00);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R12 status unchanged", v, 8'h80);

    // deselected strobes ignored
    @(negedge clk); a0 = 1'b1; db_in = 8'h08; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    #1 chk("R1 db_oe off when deselected", 8'(db_oe), 8'h00);
    @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R1 write ignored", v, 8'h80);
    chk("R1 int untouched", 8'(int_req), 8'h01);

    // interrupt status query with pending interrupt
    wr_data(8'h08, 1'b0, pk); chk("R3 ready low after write", 8'(pk[7]), 8'h00);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R7 result status", v, 8'hD0);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R12 status read no pop", v, 8'hD0);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R7 first byte", v, 8'hC0);
    chk("R7 int held mid-result", 8'(int_req), 8'h01);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R7 second byte", v, 8'h00);
    chk("R7 int cleared", 8'(int_req), 8'h00);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R7 back to idle", v, 8'h80);

    // query without interrupt, then every other unknown opcode
    wr_data(8'h08, 1'b0, pk);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R8 query no pending", v, 8'h80);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R8 idle after", v, 8'h80);
    for (int op = 0; op < 256; op++) begin
      if (op != 3 && op != 8) begin
        wr_data(8'(op), 1'b0, pk);
        rd_reg(1'b0, 1'b0, 1'b0, v); chk($sformatf("R8 op %0h status", op), v, 8'hD0);
        rd_reg(1'b1, 1'b0, 1'b0, v); chk($sformatf("R8 op %0h byte", op), v, 8'h80);
        rd_reg(1'b0, 1'b0, 1'b0, v); chk($sformatf("R8 op %0h idle", op), v, 8'h80);
      end
    end

    // specify sweep
    for (int i = 0; i < 16; i++) begin
      b1 = {4'(i), 4'(15 - i)};
      b2 = {7'((i * 37 + 5) % 128), 1'b1};
      wr_data(8'h03, 1'b0, pk);
      rd_reg(1'b0, 1'b0, 1'b0, v); chk("R4 busy in command", v, 8'h90);
      wr_data(b1, 1'b0, pk);
      wr_data(b2, 1'b0, pk);
      chk("R4 step_rate", 8'(step_rate), 8'(b1 >> 4));
      chk("R4 unload_time", 8'(unload_time), 8'(b1 & 8'h0F));
      chk("R4 load_time", 8'(load_time), 8'(b2 >> 1));
      rd_reg(1'b0, 1'b0, 1'b0, v); chk("R4 idle after specify", v, 8'h80);
    end

    // reset keeps timing values; rdy low gives no interrupt
    b1 = {4'(15), 4'(0)};
    b2 = {7'((15 * 37 + 5) % 128), 1'b1};
    do_reset(1'b0);
    chk("R5 step kept", 8'(step_rate), 8'(b1 >> 4));
    chk("R5 unload kept", 8'(unload_time), 8'(b1 & 8'h0F));
    chk("R5 load kept", 8'(load_time), 8'(b2 >> 1));
    repeat (INT_DELAY + 5) @(negedge clk);
    chk("R6 no int when rdy low", 8'(int_req), 8'h00);

    // write during result phase
    do_reset(1'b1);
    repeat (INT_DELAY + 2) @(negedge clk);
    chk("R6 int raised again", 8'(int_req), 8'h01);
    wr_data(8'h08, 1'b0, pk);
    wr_data(8'h03, 1'b0, pk);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R9 still result", v, 8'hD0);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R9 invalid replaces", v, 8'h80);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R9 idle after", v, 8'h80);
    chk("R9 int kept", 8'(int_req), 8'h01);
    wr_data(8'h08, 1'b0, pk);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R7 retry first", v, 8'hC0);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R7 retry second", v, 8'h00);
    chk("R7 retry clears int", 8'(int_req), 8'h00);

    // DMA mode, DMA access and terminal count
    do_reset(1'b1);
    repeat (INT_DELAY + 2) @(negedge clk);
    wr_data(8'h03, 1'b0, pk);
    wr_data(8'h12, 1'b0, pk);
    wr_data(8'h10, 1'b0, pk);
    chk("R10 drq low idle", 8'(drq), 8'h00);
    wr_data(8'h08, 1'b1, pk);
    chk("R10 drq in result", 8'(drq), 8'h01);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R2 dma write reached data port", v, 8'hD0);
    rd_reg(1'b0, 1'b1, 1'b1, v); chk("R2 dma read ignores a0", v, 8'hC0);
    rd_reg(1'b0, 1'b0, 1'b0, v); chk("R11 tc ends result", v, 8'h80);
    chk("R11 int cleared by tc", 8'(int_req), 8'h00);
    chk("R10 drq low after", 8'(drq), 8'h00);
    do_reset(1'b0);
    wr_data(8'hFF, 1'b0, pk);
    chk("R10 reset restores non-DMA", 8'(drq), 8'h00);
    rd_reg(1'b1, 1'b0, 1'b0, v); chk("R8 op ff", v, 8'h80);

    finish_run();
  end
endmodule